// File: doc/BRIEF.md
# Synchronous Slave Serial Receiver

This block receives words over a two-wire synchronous serial link in which a remote master drives both the shift clock and the data line. The clock and data lines are brought into the system clock domain, and data is taken on each falling edge of the remote clock, least significant bit first. Bits collect in an internal shift register. When a word is complete (8 bits, or 9 bits when wide mode is on), it moves into a holding register that the host reads through a small register port. A ready flag is then raised, and it can also drive an interrupt.

Because the remote side supplies the clock, reception continues while the host sleeps. A completed word with the interrupt enabled then raises a wake request. If a word completes while the previous one is still unread, an overrun is latched and no more words are delivered. The only way to clear that error is to turn the continuous-receive enable off. The single-word request bit is meant for master operation and has no effect here.

Register map (2-bit address). Address 0 is control: bit0 port enable, bit1 synchronous mode, bit2 clock-source select (1 = internal master clock), bit3 wide 9-bit mode, bit4 continuous receive enable, bit5 single-word request, bit6 interrupt enable. Address 1 is status and is read only: bit0 ready, bit1 overrun, bit7 ninth data bit. Address 2 is the received data.

Top module: `sync_slave_rx`

## Requirements
- R1: Words are received only when control bits 0, 1 and 4 are set and bit 2 is clear. In any other setting, clock edges on the serial inputs deliver no word.
- R2: The single-word request (control bit5) has no effect. With bit4 clear, no word is received even when bit5 is set.
- R3: Each bit is taken on a falling edge of the serial clock, and the first bit taken is the least significant. In 8-bit mode, eight edges deliver one byte to the data register (address 2).
- R4: When control bit3 is set, a word is nine bits. Its low eight bits go to the data register and its ninth bit appears as status bit7.
- R5: Delivery of a word into the data register sets status bit0 (ready).
- R6: A read of the data register clears status bit0.
- R7: The interrupt output is high exactly while status bit0 and control bit6 are both set.
- R8: The wake output is high when the interrupt output is high and the host sleep input is asserted, and low otherwise.
- R9: If a word completes while status bit0 is set, status bit1 (overrun) is set and the data register is left unchanged. While bit1 is set, later words are not delivered and do not set bit0.
- R10: Writing control bit4 to zero clears status bit1.
- R11: After reset, status bits 6..0 read zero, the interrupt and wake outputs are low, and control reads zero. Status bit7 is unspecified after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Shift clock from the remote master |
| ser_dat_i | input | 1 | Serial data from the remote master |
| sleep_i | input | 1 | High while the host is in a low-power state |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; a read at address 2 clears ready |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Receive interrupt request |
| wake_o | output | 1 | Wake request to the host |

## Verification
The assertions assume a serial clock that stays at each level for several system clocks, so the synchronizer never misses or merges an edge. They also assume that the sleep input holds steady around a word delivery. The stimulus meets both conditions: each half period of the remote clock lasts six system clocks, and sleep is changed only while the link is idle. Data is set up at the rising edge of the remote clock, before the edge that samples it.

// File: rtl/sync_slave_rx_pkg.sv
package sync_slave_rx_pkg;

   localparam int unsigned BUS_W  = 8;
   localparam int unsigned ADDR_W = 2;

   localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] ADR_STAT = 2'd1;
   localparam logic [ADDR_W-1:0] ADR_DATA = 2'd2;

   localparam int unsigned ST_READY = 0;
   localparam int unsigned ST_OVR   = 1;
   localparam int unsigned ST_NINTH = 7;

   // packed MSB first: field order gives bit6 .. bit0
   typedef struct packed {
      logic irq_en;      // bit6
      logic single_req;  // bit5
      logic rx_on;       // bit4
      logic wide9;       // bit3
      logic clk_master;  // bit2
      logic sync_mode;   // bit1
      logic port_en;     // bit0
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/sync_slave_rx_sync.sv
module sync_slave_rx_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sync_slave_rx_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
      end
      assign sync_o[b] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/sync_slave_rx_shift.sv
module sync_slave_rx_shift #(
   parameter int unsigned WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic              wide_i,
   input  logic              sck_s_i,
   input  logic              sdi_s_i,
   output logic              done_o,
   output logic [WORD_W:0]   word_o,
   output logic [$clog2(WORD_W+2)-1:0] cnt_o
);

   localparam int unsigned MAX_W = WORD_W + 1;
   localparam int unsigned CNT_W = $clog2(WORD_W + 2);

   if (WORD_W < 2) begin : g_bad_word
      $error("sync_slave_rx_shift: WORD_W must be at least 2");
   end

   logic             sck_q;
   logic             fall;
   logic [MAX_W-1:0] sh_q;
   logic [MAX_W-1:0] sh_next;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_idx;
   logic             last_bit;

   assign fall     = sck_q & ~sck_s_i;
   assign sh_next  = {sdi_s_i, sh_q[MAX_W-1:1]};
   assign last_idx = wide_i ? CNT_W'(MAX_W - 1) : CNT_W'(WORD_W - 1);
   assign last_bit = (cnt_q == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_s_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         cnt_q  <= '0;
         done_o <= 1'b0;
         word_o <= '0;
      end else begin
         done_o <= 1'b0;
         if (!active_i) begin
            cnt_q <= '0;
         end else if (fall) begin
            sh_q <= sh_next;
            if (last_bit) begin
               cnt_q  <= '0;
               done_o <= 1'b1;
               if (wide_i) word_o <= sh_next;
               else        word_o <= {1'b0, sh_next[MAX_W-1:1]};
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/sync_slave_rx_regs.sv
module sync_slave_rx_regs
   import sync_slave_rx_pkg::*;
#(
   parameter int unsigned WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              done_i,
   input  logic [WORD_W:0]   word_i,
   output ctrl_t             ctrl_o,
   output logic              ready_o,
   output logic              ovr_o,
   output logic [WORD_W-1:0] data_o
);

   if (WORD_W != BUS_W) begin : g_bad_width
      $error("sync_slave_rx_regs: WORD_W must equal the bus width");
   end

   ctrl_t             ctrl_q;
   logic              ready_q;
   logic              ovr_q;
   logic              ninth_q;
   logic [WORD_W-1:0] data_q;
   logic              wr_ctrl;
   logic              rd_data;
   logic              rx_off;
   logic              load;
   ctrl_t             wctrl;

   assign wctrl   = ctrl_t'(bus_wdata[CTRL_W-1:0]);
   assign wr_ctrl = bus_we && (bus_addr == ADR_CTRL);
   assign rd_data = bus_re && (bus_addr == ADR_DATA);
   assign rx_off  = wr_ctrl ? !wctrl.rx_on : !ctrl_q.rx_on;
   assign load    = done_i && (!ready_q || rd_data) && !ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= wctrl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         ovr_q   <= 1'b0;
         ninth_q <= 1'b0;
         data_q  <= '0;
      end else begin
         if (load) begin
            data_q  <= word_i[WORD_W-1:0];
            ninth_q <= word_i[WORD_W];
            ready_q <= 1'b1;
         end else if (rd_data) begin
            ready_q <= 1'b0;
         end
         if (rx_off)
            ovr_q <= 1'b0;
         else if (done_i && ready_q && !rd_data)
            ovr_q <= 1'b1;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADR_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
         ADR_STAT: begin
            bus_rdata[ST_READY] = ready_q;
            bus_rdata[ST_OVR]   = ovr_q;
            bus_rdata[ST_NINTH] = ninth_q;
         end
         ADR_DATA: bus_rdata = data_q;
         default:  bus_rdata = '0;
      endcase
   end

   assign ctrl_o  = ctrl_q;
   assign ready_o = ready_q;
   assign ovr_o   = ovr_q;
   assign data_o  = data_q;

endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
   import sync_slave_rx_pkg::*;
#(
   parameter int unsigned WORD_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_dat_i,
   input  logic              sleep_i,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq_o,
   output logic              wake_o
);

   localparam int unsigned CNT_W = $clog2(WORD_W + 2);

   logic [1:0]        ser_s;
   logic              active;
   logic              word_done;
   logic [WORD_W:0]   word;
   logic [CNT_W-1:0]  bit_cnt;
   ctrl_t             ctrl;
   logic              ready;
   logic              ovr;
   logic [WORD_W-1:0] data_q;

   sync_slave_rx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({ser_dat_i, ser_clk_i}),
      .sync_o  (ser_s)
   );

   assign active = ctrl.port_en && ctrl.sync_mode && !ctrl.clk_master && ctrl.rx_on;

   sync_slave_rx_shift #(.WORD_W(WORD_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active),
      .wide_i   (ctrl.wide9),
      .sck_s_i  (ser_s[0]),
      .sdi_s_i  (ser_s[1]),
      .done_o   (word_done),
      .word_o   (word),
      .cnt_o    (bit_cnt)
   );

   sync_slave_rx_regs #(.WORD_W(WORD_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_re    (bus_re),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .done_i    (word_done),
      .word_i    (word),
      .ctrl_o    (ctrl),
      .ready_o   (ready),
      .ovr_o     (ovr),
      .data_o    (data_q)
   );

   assign irq_o  = ready && ctrl.irq_en;
   assign wake_o = irq_o && sleep_i;

endmodule

// File: rtl/sync_slave_rx_chk.sv
module sync_slave_rx_chk #(
   parameter int unsigned WORD_W = 8,
   parameter int unsigned CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sleep_i,
   input logic [1:0]        bus_addr,
   input logic              bus_we,
   input logic              bus_re,
   input logic [7:0]        bus_wdata,
   input logic              irq_o,
   input logic              wake_o,
   input logic              word_done,
   input logic              ready,
   input logic              ovr,
   input logic              irq_en,
   input logic [WORD_W-1:0] data_q,
   input logic [CNT_W-1:0]  bit_cnt
);

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(WORD_W));

   // R5
   ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && !ready && !ovr) |=> ready);

   // R6
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr == 2'd2 && !word_done) |=> !ready);

   // R7
   irq_on_delivery_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && !ready && !ovr && irq_en && !(bus_we && bus_addr == 2'd0)) |=> irq_o);

   // R8
   wake_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> sleep_i);

   // R9
   ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |=> $stable(data_q));

   // R10
   ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 2'd0 && !bus_wdata[4]) |=> !ovr);

endmodule

bind sync_slave_rx sync_slave_rx_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sleep_i   (sleep_i),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_re    (bus_re),
   .bus_wdata (bus_wdata),
   .irq_o     (irq_o),
   .wake_o    (wake_o),
   .word_done (word_done),
   .ready     (ready),
   .ovr       (ovr),
   .irq_en    (ctrl.irq_en),
   .data_q    (data_q),
   .bit_cnt   (bit_cnt)
);

// File: tb/sim_sync_slave_rx.sv
module sim_sync_slave_rx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk = 1'b0;
   logic       ser_dat = 1'b0;
   logic       sleep = 1'b0;
   logic [1:0] addr = 2'd0;
   logic       we = 1'b0;
   logic       re = 1'b0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       irq;
   logic       wake;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   sync_slave_rx u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_clk_i (ser_clk),
      .ser_dat_i (ser_dat),
      .sleep_i   (sleep),
      .bus_addr  (addr),
      .bus_we    (we),
      .bus_re    (re),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .irq_o     (irq),
      .wake_o    (wake)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; re = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      re = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; re = 1'b0;
      #1 d = rdata;
   endtask

   task automatic send(input logic [8:0] v, input int nb);
      for (int i = 0; i < nb; i++) begin
         @(negedge clk);
         ser_dat = v[i];
         ser_clk = 1'b1;
         repeat (6) @(negedge clk);
         ser_clk = 1'b0;
         repeat (6) @(negedge clk);
      end
      repeat (8) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      peek(2'd1, d);
      check("R11 status after reset", {8'h0, d & 8'h7F}, 16'h0);
      peek(2'd0, d);
      check("R11 control after reset", {8'h0, d}, 16'h0);
      check("R11 irq after reset", {15'h0, irq}, 16'h0);
      check("R11 wake after reset", {15'h0, wake}, 16'h0);
   endtask

   task automatic t_byte();
      logic [7:0] d;
      wr(2'd0, 8'h13);
      send(9'h0A5, 8);
      peek(2'd1, d);
      check("R5 ready after word", {15'h0, d[0]}, 16'h1);
      check("R7 irq off when disabled", {15'h0, irq}, 16'h0);
      rd(2'd2, d);
      check("R3 byte lsb first", {8'h0, d}, 16'h00A5);
      peek(2'd1, d);
      check("R6 ready cleared by read", {15'h0, d[0]}, 16'h0);
   endtask

   task automatic t_irq();
      logic [7:0] d;
      wr(2'd0, 8'h53);
      send(9'h03C, 8);
      check("R7 irq with enable", {15'h0, irq}, 16'h1);
      check("R8 no wake while awake", {15'h0, wake}, 16'h0);
      @(negedge clk); sleep = 1'b1;
      #1 check("R8 wake while asleep", {15'h0, wake}, 16'h1);
      rd(2'd2, d);
      check("R3 second byte", {8'h0, d}, 16'h003C);
      check("R7 irq drops after read", {15'h0, irq}, 16'h0);
      check("R8 wake drops after read", {15'h0, wake}, 16'h0);
      @(negedge clk); sleep = 1'b0;
   endtask

   task automatic t_nine();
      logic [7:0] d;
      wr(2'd0, 8'h1B);
      send(9'h1C3, 9);
      peek(2'd1, d);
      check("R4 ninth bit set", {15'h0, d[7]}, 16'h1);
      rd(2'd2, d);
      check("R4 low byte", {8'h0, d}, 16'h00C3);
      send(9'h05A, 9);
      peek(2'd1, d);
      check("R4 ninth bit clear", {15'h0, d[7]}, 16'h0);
      rd(2'd2, d);
      check("R4 low byte second", {8'h0, d}, 16'h005A);
   endtask

   task automatic t_overrun();
      logic [7:0] d;
      wr(2'd0, 8'h13);
      send(9'h011, 8);
      send(9'h022, 8);
      peek(2'd1, d);
      check("R9 overrun latched", {15'h0, d[1]}, 16'h1);
      rd(2'd2, d);
      check("R9 data kept first", {8'h0, d}, 16'h0011);
      send(9'h033, 8);
      peek(2'd1, d);
      check("R9 no ready while overrun", {15'h0, d[0]}, 16'h0);
      peek(2'd2, d);
      check("R9 data frozen", {8'h0, d}, 16'h0011);
   endtask

   task automatic t_clear();
      logic [7:0] d;
      wr(2'd0, 8'h03);
      peek(2'd1, d);
      check("R10 overrun cleared", {15'h0, d[1]}, 16'h0);
      wr(2'd0, 8'h13);
      send(9'h044, 8);
      rd(2'd2, d);
      check("R10 reception resumes", {8'h0, d}, 16'h0044);
   endtask

   task automatic t_modes();
      logic [7:0] d;
      wr(2'd0, 8'h23);
      send(9'h055, 8);
      peek(2'd1, d);
      check("R2 single request ignored", {15'h0, d[0]}, 16'h0);
      wr(2'd0, 8'h17);
      send(9'h066, 8);
      peek(2'd1, d);
      check("R1 internal clock select blocks", {15'h0, d[0]}, 16'h0);
      wr(2'd0, 8'h11);
      send(9'h077, 8);
      peek(2'd1, d);
      check("R1 async mode blocks", {15'h0, d[0]}, 16'h0);
      peek(2'd2, d);
      check("R1 data untouched", {8'h0, d}, 16'h0044);
      wr(2'd0, 8'h13);
      send(9'h088, 8);
      rd(2'd2, d);
      check("R1 slave mode receives", {8'h0, d}, 16'h0088);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_byte();
      t_irq();
      t_nine();
      t_overrun();
      t_clear();
      t_modes();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule